// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit processor pipeline and a data memory that is byte-addressed but stored as 32-bit words. On the request side it adds a sign-extended 16-bit offset to a base value to form the effective address. For stores it produces a per-lane write enable and steers the store data onto the correct byte lanes. Any halfword or word access that is not naturally aligned is refused. The unit raises an error flag for it, and no memory lane is written.

On the return side, the unit takes the word that memory delivers for an outstanding load and picks out the addressed byte, halfword or full word. It then widens the value to 32 bits by sign or zero extension and presents it from a register. Lane order is big-endian: the byte at the lowest address of a word travels in bits 31:24. The access size and the signedness come from the instruction decoder. The unit keeps the low address bits, the size and the signedness of the last accepted load, and uses them when the read data arrives.

Top module: `mem_align_unit`

## Requirements
- R1: While a request is presented, `mem_addr` equals `base_addr` plus `offset_imm` sign-extended from 16 to 32 bits, with the sum taken modulo 2^32.
- R2: A byte store (size code 00) drives the low 8 bits of `store_data` onto all four lanes of `mem_wr_data`. Exactly one write enable is raised: bit 3-k, where k is the effective address modulo 4. Enable bit 3 covers bits 31:24, the lowest address.
- R3: A halfword store (size code 01) at an even address drives `store_data[15:0]` onto both lane pairs. It enables lanes 3 and 2 (`4'b1100`) when address bit 1 is 0, and lanes 1 and 0 (`4'b0011`) when address bit 1 is 1.
- R4: A word store (size code 10) at an address that is a multiple of 4 drives `store_data` unchanged and raises all four write enables.
- R5: The following requests raise `align_err` with every write enable low: a halfword at an odd address, a word at an address not divisible by 4, or size code 11. `align_err` is low whenever `req_valid` is low.
- R6: A load request (`req_store` low) never raises a write enable.
- R7: A byte load returns bits [31-8k:24-8k] of the read word, where k is the load's address modulo 4. The value is sign-extended when `req_signed` was 1 and zero-extended when it was 0.
- R8: A halfword load at offset k (0 or 2) returns bits [31-8k:16-8k] of the read word, with the same signed or unsigned extension as R7.
- R9: A word load returns the read word unchanged, whatever the signedness.
- R10: `ld_valid` is high exactly in the cycle after a cycle with `rd_valid` high. `ld_data` changes only on such a return and otherwise holds its value. After reset, both outputs are zero.
- R11: A load request that fails the alignment check does not replace the stored context of the previous accepted load. A later read return is decoded with that earlier size, signedness and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| req_signed | input | 1 | Sign-extend a sub-word load |
| base_addr | input | 32 | Base register value |
| offset_imm | input | 16 | Signed address offset |
| store_data | input | 32 | Store source register value |
| mem_addr | output | 32 | Effective byte address |
| mem_wr_en | output | 4 | Per-lane write enable, bit 3 = lowest address |
| mem_wr_data | output | 32 | Lane-steered store data |
| align_err | output | 1 | Misaligned or invalid access |
| rd_valid | input | 1 | Memory returns the word for the outstanding load |
| rd_word | input | 32 | Word read from memory |
| ld_valid | output | 1 | Extended load result is valid |
| ld_data | output | 32 | Extended load result |

## Verification
The request side has no state, so a wrong lane decode shows at `mem_wr_en`, `mem_wr_data` or `align_err` in the same cycle as the request. The stored load context is the only internal state. If it is captured from the wrong request, or overwritten by a refused load, the error first appears as a wrong `ld_data` one clock after the next `rd_valid`. The bench therefore pairs each refused load with a later return and checks the data against the earlier accepted request. A stuck or wrongly enabled result register shows as `ld_data` moving in a cycle without a return, or as `ld_valid` out of step with `rd_valid` by one cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  // context kept for the load that is waiting for its read data
  typedef struct packed {
    logic [1:0] lane_off;
    acc_size_e  size;
    logic       sext;
  } ld_ctx_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misaligned
);
  localparam int EXT_W = ADDR_W - IMM_W;

  assign eff_addr = base + {{EXT_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    unique case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = eff_addr[0];
      SZ_WORD: misaligned = |eff_addr[LANE_W-1:0];
      default: misaligned = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] off,
  input  acc_size_e         size,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  we,
  output logic [DATA_W-1:0] wdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // lane g carries the byte at address offset K (big-endian order)
    localparam int K = LANES - 1 - g;
    localparam logic [LANE_W-1:0] KOFF = K[LANE_W-1:0];
    logic hit;

    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          wdata[8*g +: 8] = data[7:0];
          hit             = (off == KOFF);
        end
        SZ_HALF: begin
          wdata[8*g +: 8] = KOFF[0] ? data[7:0] : data[15:8];
          hit             = (off[LANE_W-1:1] == KOFF[LANE_W-1:1]);
        end
        default: begin
          wdata[8*g +: 8] = data[8*g +: 8];
          hit             = 1'b1;
        end
      endcase
    end

    assign we[g] = wr_ok & hit;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] word,
  input  ld_ctx_t           ctx,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] aligned;
  logic [7:0]        b;
  logic [15:0]       h;

  // move the addressed byte up to the top lane
  assign aligned = word << {ctx.lane_off, 3'b000};
  assign b       = aligned[DATA_W-1 -: 8];
  assign h       = aligned[DATA_W-1 -: 16];

  always_comb begin
    unique case (ctx.size)
      SZ_BYTE: value = {{(DATA_W-8){ctx.sext & b[7]}}, b};
      SZ_HALF: value = {{(DATA_W-16){ctx.sext & h[15]}}, h};
      default: value = word;
    endcase
  end
endmodule

// File: rtl/mem_align_unit.sv
module mem_align_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IMM_W-1:0]  offset_imm,
  input  logic [DATA_W-1:0] store_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_wr_en,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              align_err,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  acc_size_e size;
  logic      misaligned;
  logic      wr_ok;
  assign size = acc_size_e'(req_size);

  lsu_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .LANE_W(LANE_W)) u_agen (
    .base       (base_addr),
    .imm        (offset_imm),
    .size       (size),
    .eff_addr   (mem_addr),
    .misaligned (misaligned)
  );

  assign align_err = req_valid & misaligned;
  assign wr_ok     = req_valid & req_store & ~misaligned;

  lsu_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .off   (mem_addr[LANE_W-1:0]),
    .size  (size),
    .wr_ok (wr_ok),
    .data  (store_data),
    .we    (mem_wr_en),
    .wdata (mem_wr_data)
  );

  // load context and result registers
  ld_ctx_t           ctx_q, ctx_d;
  logic              ctx_en;
  logic [DATA_W-1:0] ext_val;
  logic [DATA_W-1:0] ld_data_d;
  logic              ld_valid_d;

  lsu_load_extract #(.DATA_W(DATA_W)) u_ext (
    .word  (rd_word),
    .ctx   (ctx_q),
    .value (ext_val)
  );

  always_comb begin
    ctx_en     = req_valid & ~req_store & ~misaligned;
    ctx_d      = ctx_q;
    if (ctx_en) begin
      ctx_d.lane_off = mem_addr[LANE_W-1:0];
      ctx_d.size     = size;
      ctx_d.sext     = req_signed;
    end
    ld_valid_d = rd_valid;
    ld_data_d  = rd_valid ? ext_val : ld_data;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctx_q    <= '0;
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ctx_q    <= ctx_d;
      ld_valid <= ld_valid_d;
      ld_data  <= ld_data_d;
    end
  end
endmodule

// File: rtl/lsu_align_checker.sv
module lsu_align_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_store,
  input logic [1:0]        req_size,
  input logic [DATA_W/8-1:0] mem_wr_en,
  input logic              align_err,
  input logic              rd_valid,
  input logic              ld_valid,
  input logic [DATA_W-1:0] ld_data
);
  assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b00) |-> $countones(mem_wr_en) == 1);

  assert_err_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> mem_wr_en == '0);

  assert_err_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !align_err);

  assert_load_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store) |-> mem_wr_en == '0);

  assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b10 && !align_err) |-> mem_wr_en == '1);

  assert_ld_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(ld_data) && !ld_valid));
endmodule

bind mem_align_unit lsu_align_checker #(.DATA_W(DATA_W)) u_align_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_store (req_store),
  .req_size  (req_size),
  .mem_wr_en (mem_wr_en),
  .align_err (align_err),
  .rd_valid  (rd_valid),
  .ld_valid  (ld_valid),
  .ld_data   (ld_data)
);

// File: tb/tb_mem_align_unit.sv
`timescale 1ns/1ps
module tb_mem_align_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_store, req_signed, rd_valid;
  logic [1:0]  req_size;
  logic [31:0] base_addr, store_data, rd_word;
  logic [15:0] offset_imm;
  logic [31:0] mem_addr, mem_wr_data, ld_data;
  logic [3:0]  mem_wr_en;
  logic        align_err, ld_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  int          m_off = 0;
  int          m_n   = 1;
  bit          m_sg  = 0;
  logic        e_ldv = 1'b0;
  logic [31:0] e_ldd = 32'h0;

  always #4 clk = ~clk;

  mem_align_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .base_addr(base_addr),
    .offset_imm(offset_imm), .store_data(store_data), .mem_addr(mem_addr),
    .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data), .align_err(align_err),
    .rd_valid(rd_valid), .rd_word(rd_word), .ld_valid(ld_valid), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string size_tag(input int n);
    if (n == 1) return "R2";
    if (n == 2) return "R3";
    return "R4";
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input int off,
                                          input int n, input bit sg);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v = (v << 8) | 32'(w[8*(3-(off+i)) +: 8]);
    if (n < 4 && sg && v[8*n-1]) v = v | ~((32'h1 << (8*n)) - 1);
    return v;
  endfunction

  task automatic step(input bit v, input bit st, input logic [1:0] sz, input bit sg,
                      input logic [31:0] base, input logic [15:0] imm,
                      input logic [31:0] sd, input bit rv, input logic [31:0] rw);
    logic [31:0] ea, ewd;
    logic [3:0]  ewe;
    int n, off;
    bit ok;
    string ltag;
    req_valid = v; req_store = st; req_size = sz; req_signed = sg;
    base_addr = base; offset_imm = imm; store_data = sd;
    rd_valid = rv; rd_word = rw;
    ea  = base + {{16{imm[15]}}, imm};
    n   = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    off = int'(ea[1:0]);
    ok  = (sz != 2'b11) && (off % n == 0);
    ewe = 4'b0000;
    ewd = 32'h0;
    if (v && st && ok) begin
      for (int k = 0; k < 4; k++) begin
        if (k >= off && k < off + n) ewe[3-k] = 1'b1;
        ewd[8*(3-k) +: 8] = sd[8*((n-1) - (k % n)) +: 8];
      end
    end
    #1;
    if (v) chk("R1 mem_addr", mem_addr, ea);
    chk("R5 align_err", {31'h0, align_err}, {31'h0, v && !ok});
    if (v && !st) chk("R6 load write enable", {28'h0, mem_wr_en}, 32'h0);
    else if (v && !ok) chk("R5 write enable on error", {28'h0, mem_wr_en}, 32'h0);
    else if (v) begin
      chk({size_tag(n), " write enable"}, {28'h0, mem_wr_en}, {28'h0, ewe});
      chk({size_tag(n), " write data"}, mem_wr_data, ewd);
    end
    @(posedge clk);
    ltag = (m_n == 1) ? "R7" : (m_n == 2) ? "R8" : "R9";
    if (rv) begin
      e_ldv = 1'b1;
      e_ldd = extract(rw, m_off, m_n, m_sg);
    end else e_ldv = 1'b0;
    if (v && !st && ok) begin
      m_off = off; m_n = n; m_sg = sg;
    end
    @(negedge clk);
    #1;
    chk("R10 ld_valid", {31'h0, ld_valid}, {31'h0, e_ldv});
    chk(rv ? {ltag, " ld_data"} : "R10 ld_data hold", ld_data, e_ldd);
  endtask

  task automatic idle();
    step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 0, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
    base_addr = 0; offset_imm = 0; store_data = 0; rd_valid = 0; rd_word = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset ld_valid", {31'h0, ld_valid}, 32'h0);
    chk("R10 reset ld_data", ld_data, 32'h0);
    chk("R5 reset align_err", {31'h0, align_err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // byte stores at every offset, positive and negative immediates (R1, R2)
    for (int k = 0; k < 4; k++)
      step(1, 1, 2'b00, 0, 32'h0000_1000, 16'(k), 32'h1234_56A5, 0, 32'h0);
    step(1, 1, 2'b00, 0, 32'h0000_1000, 16'hFFFF, 32'h0000_00C3, 0, 32'h0);
    step(1, 1, 2'b00, 0, 32'h0000_0002, 16'hFFFC, 32'hFFFF_FF7E, 0, 32'h0);
    // halfword stores (R3), word stores (R4)
    step(1, 1, 2'b01, 0, 32'h0000_2000, 16'h0000, 32'hDEAD_BEEF, 0, 32'h0);
    step(1, 1, 2'b01, 0, 32'h0000_2000, 16'h0002, 32'hDEAD_BEEF, 0, 32'h0);
    step(1, 1, 2'b10, 0, 32'h0000_3004, 16'hFFFC, 32'hAA15_13FF, 0, 32'h0);
    // misaligned and invalid (R5)
    step(1, 1, 2'b01, 0, 32'h0000_2001, 16'h0000, 32'h1111_2222, 0, 32'h0);
    step(1, 1, 2'b10, 0, 32'h0000_2000, 16'h0002, 32'h1111_2222, 0, 32'h0);
    step(1, 1, 2'b10, 0, 32'h0000_2003, 16'h0000, 32'h1111_2222, 0, 32'h0);
    step(1, 1, 2'b11, 0, 32'h0000_2000, 16'h0000, 32'h1111_2222, 0, 32'h0);
    step(0, 1, 2'b10, 0, 32'h0000_2003, 16'h0000, 32'h1111_2222, 0, 32'h0);

    // byte loads at each offset, signed and unsigned (R6, R7)
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 2; s++) begin
        step(1, 0, 2'b00, bit'(s), 32'h0000_0000, 16'(k), 32'h0, 0, 32'h0);
        step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 1, 32'hAA15_13FF);
      end
    end
    // halfword loads (R8)
    for (int k = 0; k < 2; k++) begin
      for (int s = 0; s < 2; s++) begin
        step(1, 0, 2'b01, bit'(s), 32'h0000_0100, 16'(2*k), 32'h0, 0, 32'h0);
        step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 1, 32'h8001_7FFE);
      end
    end
    // word load, signed flag irrelevant (R9)
    step(1, 0, 2'b10, 1, 32'h0000_0200, 16'h0000, 32'h0, 0, 32'h0);
    step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 1, 32'hF00D_CAFE);
    // result holds while no return (R10)
    idle();
    step(1, 0, 2'b00, 1, 32'h0000_0000, 16'h0003, 32'h0, 0, 32'h0);
    idle();
    // refused load keeps earlier context (R11)
    step(1, 0, 2'b01, 0, 32'h0000_0001, 16'h0000, 32'h0, 0, 32'h0);
    step(1, 0, 2'b10, 0, 32'h0000_0002, 16'h0000, 32'h0, 0, 32'h0);
    step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 1, 32'h1234_5680);
    // back-to-back returns with a new load in the same cycle as a return (R10, R11)
    step(1, 0, 2'b01, 1, 32'h0000_0000, 16'h0002, 32'h0, 1, 32'h0000_00F1);
    step(0, 0, 2'b00, 0, 32'h0, 16'h0, 32'h0, 1, 32'h0000_9ABC);
    idle();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule